// File: doc/BRIEF.md
# Hardware Cursor Overlay Mixer

This block places a small two-colour pointer image over a stream of scan-out pixels. Software writes the pointer position and two 32-row bitmaps over a 32-bit register bus. The first bitmap (mask) marks which pointer pixels are opaque. The second bitmap (image) picks one of two overlay colours for each opaque pixel.

For every pixel the display pipeline presents, the block receives the screen x and y coordinates and the underlying 8-bit palette index. One cycle later it returns a 9-bit colour index. That index is either the underlying index, zero-extended, or one of the two overlay entries 258 and 259. The palette that turns these indices into colours, and the video timing that produces the coordinates, sit outside this block.

A general-purpose miscellaneous register sits in the same register space. It stores whatever is written to it, and its readback always shows one fixed status bit set.

Top module: `cursor_mixer`

## Requirements
- R1: After reset the pointer x coordinate is 0xF000 and y is 0. A position read returns 0xF0000000, the misc register reads 0x02000000, and every mask and image row reads 0. With any screen width up to 0xF000, no pixel is overlaid.
- R2: A write to offset 0x8FC sets pointer x from data bits 31:16 and pointer y from bits 15:0. A read of 0x8FC returns {x, y}.
- R3: Mask row r sits at offset 0x900 + 4*r and image row r at 0x980 + 4*r, for r = 0..31. Each row is written and read back as a full 32-bit word.
- R4: A write to offset 0x818 stores the full 32-bit data word. A read of 0x818 returns the stored word with bit 25 forced to 1.
- R5: Reading any offset other than 0x8FC, 0x818 or 0x900..0x9FF returns 0. Writing such an offset changes no register.
- R6: Inside the pointer area, take row = y - pointer y and col = x - pointer x. The pixel uses bit (31 - col) of mask row `row` and of image row `row`. Mask bit 0 outputs the underlying index. Mask 1 with image 1 outputs 259. Mask 1 with image 0 outputs 258.
- R7: Only lines with pointer y <= y < pointer y + 32 can be overlaid. The comparison does not wrap at 16 bits.
- R8: Only columns with pointer x <= x < pointer x + 32 and x < screenWidth can be overlaid. No pixel is overlaid while pointer x >= screenWidth.
- R9: outValid equals pixValid delayed by one clock. outIndex belongs to the pixel presented one clock earlier. regRdData is updated one clock after a read strobe and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 12 | Register byte offset |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data, one cycle after regRdEn |
| screenWidth | input | 16 | Active screen width in pixels |
| pixValid | input | 1 | Pixel input valid |
| pixX | input | 16 | Pixel column |
| pixY | input | 16 | Pixel line |
| pixIndex | input | 8 | Underlying palette index |
| outValid | output | 1 | Output pixel valid |
| outIndex | output | 9 | Mixed palette index (0..255, 258 or 259) |

## Verification
A corrupted bitmap row or a misdecoded row index shows up on outIndex on the first pixel that crosses the affected pointer line. It appears one clock after that pixel, as a wrong choice among passthrough, 258 and 259. A wrong position register or a window comparison that is off by one shows up only at the pointer edges. For that reason the sweeps cover a two-pixel margin around the 32x32 area, and they include a line range that wraps past 0xFFFF, a pointer cut by the right screen edge and a pointer sitting exactly at the edge. A wrong register decode shows up on regRdData one clock after the read.

// File: rtl/cursor_mixer_pkg.sv
package cursor_mixer_pkg;
  localparam int unsigned CUR_DIM = 32;
  localparam int unsigned ROW_W   = $clog2(CUR_DIM);

  typedef enum logic [2:0] {
    RD_ZERO,
    RD_POS,
    RD_MISC,
    RD_MASK,
    RD_IMG
  } rdSel_e;

  typedef struct packed {
    logic             posWr;
    logic             miscWr;
    logic             maskWr;
    logic             imgWr;
    logic             rdEn;
    rdSel_e           rdSel;
    logic [ROW_W-1:0] row;
  } ctrlStrobe_t;
endpackage

// File: rtl/cursor_mixer_ctrl.sv
module cursor_mixer_ctrl
  import cursor_mixer_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter logic [ADDR_W-1:0] POS_OFS   = 12'h8FC,
  parameter logic [ADDR_W-1:0] MISC_OFS  = 12'h818,
  parameter logic [ADDR_W-1:0] MASK_BASE = 12'h900,
  parameter logic [ADDR_W-1:0] IMG_BASE  = 12'h980
) (
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  output ctrlStrobe_t       strobe
);
  // Row bases must be aligned to the row span so the row index is an address slice.
  localparam logic [ADDR_W:0] SPAN     = (ADDR_W+1)'(CUR_DIM * 4);
  localparam logic [ADDR_W:0] MASK_END = {1'b0, MASK_BASE} + SPAN;
  localparam logic [ADDR_W:0] IMG_END  = {1'b0, IMG_BASE} + SPAN;

  logic posHit, miscHit, maskHit, imgHit;

  always_comb begin
    posHit  = (regAddr == POS_OFS);
    miscHit = (regAddr == MISC_OFS);
    maskHit = ({1'b0, regAddr} >= {1'b0, MASK_BASE}) && ({1'b0, regAddr} < MASK_END);
    imgHit  = ({1'b0, regAddr} >= {1'b0, IMG_BASE}) && ({1'b0, regAddr} < IMG_END);

    strobe.posWr  = regWrEn && posHit;
    strobe.miscWr = regWrEn && miscHit;
    strobe.maskWr = regWrEn && maskHit;
    strobe.imgWr  = regWrEn && imgHit;
    strobe.rdEn   = regRdEn;
    strobe.row    = regAddr[ROW_W+1:2];

    if (posHit)       strobe.rdSel = RD_POS;
    else if (miscHit) strobe.rdSel = RD_MISC;
    else if (maskHit) strobe.rdSel = RD_MASK;
    else if (imgHit)  strobe.rdSel = RD_IMG;
    else              strobe.rdSel = RD_ZERO;
  end
endmodule

// File: rtl/cursor_mixer_dp.sv
module cursor_mixer_dp
  import cursor_mixer_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned COORD_W = 16,
  parameter int unsigned PIX_W   = 8,
  parameter int unsigned FORCE_BIT = 25,
  parameter logic [COORD_W-1:0] RESET_X = 16'hF000,
  localparam int unsigned OUT_W = PIX_W + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strobe,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  input  logic [COORD_W-1:0] screenWidth,
  input  logic               pixValid,
  input  logic [COORD_W-1:0] pixX,
  input  logic [COORD_W-1:0] pixY,
  input  logic [PIX_W-1:0]   pixIndex,
  output logic               outValid,
  output logic [OUT_W-1:0]   outIndex
);
  localparam logic [OUT_W-1:0] OVL_LO = OUT_W'((1 << PIX_W) + 2);
  localparam logic [OUT_W-1:0] OVL_HI = OUT_W'((1 << PIX_W) + 3);
  localparam logic [COORD_W:0] DIM    = (COORD_W+1)'(CUR_DIM);
  localparam logic [ROW_W-1:0] LAST   = ROW_W'(CUR_DIM - 1);

  logic [COORD_W-1:0] curX, curY;
  logic [DATA_W-1:0]  miscReg;
  logic [CUR_DIM-1:0] maskRow [CUR_DIM];
  logic [CUR_DIM-1:0] imgRow  [CUR_DIM];

  // position and misc registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      curX    <= RESET_X;
      curY    <= '0;
      miscReg <= '0;
    end else begin
      if (strobe.posWr) begin
        curX <= regWrData[DATA_W-1 -: COORD_W];
        curY <= regWrData[COORD_W-1:0];
      end
      if (strobe.miscWr) miscReg <= regWrData;
    end
  end

  // bitmap rows
  for (genvar r = 0; r < CUR_DIM; r++) begin : g_row
    always_ff @(posedge clk) begin
      if (!rstN) begin
        maskRow[r] <= '0;
        imgRow[r]  <= '0;
      end else begin
        if (strobe.maskWr && strobe.row == ROW_W'(r)) maskRow[r] <= regWrData[CUR_DIM-1:0];
        if (strobe.imgWr  && strobe.row == ROW_W'(r)) imgRow[r]  <= regWrData[CUR_DIM-1:0];
      end
    end
  end

  // read path
  logic [DATA_W-1:0] rdVal;
  always_comb begin
    rdVal = '0;
    case (strobe.rdSel)
      RD_POS:  rdVal = {curX, curY};
      RD_MISC: begin
        rdVal = miscReg;
        rdVal[FORCE_BIT] = 1'b1;
      end
      RD_MASK: rdVal = DATA_W'(maskRow[strobe.row]);
      RD_IMG:  rdVal = DATA_W'(imgRow[strobe.row]);
      default: rdVal = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)            regRdData <= '0;
    else if (strobe.rdEn) regRdData <= rdVal;
  end

  // pixel mix
  logic [COORD_W:0]   relX, relY;
  logic               inY, inX, shown, hit;
  logic [ROW_W-1:0]   row, bitSel;
  logic [OUT_W-1:0]   mixIdx;

  always_comb begin
    relX   = {1'b0, pixX} - {1'b0, curX};
    relY   = {1'b0, pixY} - {1'b0, curY};
    shown  = curX < screenWidth;
    inY    = (pixY >= curY) && (relY < DIM);
    inX    = (pixX >= curX) && (relX < DIM) && (pixX < screenWidth);
    row    = relY[ROW_W-1:0];
    bitSel = LAST - relX[ROW_W-1:0];
    hit    = shown && inY && inX && maskRow[row][bitSel];
    if (hit) mixIdx = imgRow[row][bitSel] ? OVL_HI : OVL_LO;
    else     mixIdx = {1'b0, pixIndex};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outIndex <= '0;
    end else begin
      outValid <= pixValid;
      outIndex <= mixIdx;
    end
  end
endmodule

// File: rtl/cursor_mixer.sv
module cursor_mixer
  import cursor_mixer_pkg::*;
#(
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned COORD_W = 16,
  parameter int unsigned PIX_W   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic               regRdEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  input  logic [COORD_W-1:0] screenWidth,
  input  logic               pixValid,
  input  logic [COORD_W-1:0] pixX,
  input  logic [COORD_W-1:0] pixY,
  input  logic [PIX_W-1:0]   pixIndex,
  output logic               outValid,
  output logic [PIX_W:0]     outIndex
);
  ctrlStrobe_t strobe;

  cursor_mixer_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .regWrEn (regWrEn),
    .regRdEn (regRdEn),
    .regAddr (regAddr),
    .strobe  (strobe)
  );

  cursor_mixer_dp #(
    .DATA_W (DATA_W),
    .COORD_W(COORD_W),
    .PIX_W  (PIX_W)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .regWrData  (regWrData),
    .regRdData  (regRdData),
    .screenWidth(screenWidth),
    .pixValid   (pixValid),
    .pixX       (pixX),
    .pixY       (pixY),
    .pixIndex   (pixIndex),
    .outValid   (outValid),
    .outIndex   (outIndex)
  );
endmodule

// File: rtl/cursor_mixer_chk.sv
module cursor_mixer_chk (
  input logic        clk,
  input logic        rstN,
  input logic        regRdEn,
  input logic [11:0] regAddr,
  input logic [31:0] regRdData,
  input logic [15:0] screenWidth,
  input logic        pixValid,
  input logic [15:0] pixX,
  input logic [7:0]  pixIndex,
  input logic        outValid,
  input logic [8:0]  outIndex
);
  logic decoded;
  assign decoded = (regAddr == 12'h8FC) || (regAddr == 12'h818) ||
                   ((regAddr >= 12'h900) && (regAddr < 12'hA00));

  a_r9_valid_rise: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |=> outValid);
  a_r9_valid_fall: assert property (@(posedge clk) disable iff (!rstN)
    !pixValid |=> !outValid);
  a_r6_passthrough: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outIndex[8]) |-> (outIndex[7:0] == $past(pixIndex)));
  a_r8_right_clip: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && pixX >= screenWidth) |=> !outIndex[8]);
  a_r4_status_bit: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == 12'h818) |=> regRdData[25]);
  a_r5_undecoded_zero: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && !decoded) |=> (regRdData == 32'h0));
endmodule

bind cursor_mixer cursor_mixer_chk uChk (.*);

// File: tb/tb_cursor_mixer.sv
`timescale 1ns/1ps
module tb_cursor_mixer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [15:0] screenWidth = 16'd1024;
  logic        pixValid = 1'b0;
  logic [15:0] pixX = '0, pixY = '0;
  logic [7:0]  pixIndex = '0;
  logic        outValid;
  logic [8:0]  outIndex;

  int checks = 0, failures = 0;
  logic [31:0] maskRef [32];
  logic [31:0] imgRef  [32];
  int curXRef = 32'hF000, curYRef = 0, widthRef = 1024;
  logic [31:0] rd;

  always #4 clk = ~clk;

  cursor_mixer dut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(logic [11:0] a, logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(logic [11:0] a, output logic [31:0] d);
    regRdEn = 1'b1; regAddr = a;
    @(negedge clk);
    regRdEn = 1'b0;
    d = regRdData;
  endtask

  task automatic setPos(int x, int y);
    regWrite(12'h8FC, {x[15:0], y[15:0]});
    curXRef = x; curYRef = y;
  endtask

  task automatic loadBitmaps(int seed);
    for (int r = 0; r < 32; r++) begin
      maskRef[r] = 32'h9E3779B9 * (r + 1 + seed);
      imgRef[r]  = 32'h85EBCA6B * (r + 3 + seed) ^ 32'h0F0F_3C3C;
    end
    maskRef[0]  = 32'h8000_0001;
    imgRef[0]   = 32'h8000_0000;
    maskRef[31] = 32'hFFFF_FFFF;
    for (int r = 0; r < 32; r++) begin
      regWrite(12'h900 + 12'(4 * r), maskRef[r]);
      regWrite(12'h980 + 12'(4 * r), imgRef[r]);
    end
  endtask

  function automatic logic [8:0] refPix(int x, int y, logic [7:0] idx);
    int row, col;
    if (curXRef < widthRef && y >= curYRef && y < curYRef + 32 &&
        x >= curXRef && x < curXRef + 32 && x < widthRef) begin
      row = y - curYRef; col = x - curXRef;
      if (maskRef[row][31 - col]) return imgRef[row][31 - col] ? 9'd259 : 9'd258;
    end
    return {1'b0, idx};
  endfunction

  // Sweep a 36x36 window around the pointer; coordinates wrap at 16 bits.
  task automatic sweep();
    for (int dy = -2; dy < 34; dy++) begin
      for (int dx = -2; dx < 34; dx++) begin
        int x, y;
        logic [7:0] idx;
        logic [8:0] exp;
        string req;
        x = (curXRef + dx) & 16'hFFFF;
        y = (curYRef + dy) & 16'hFFFF;
        idx = 8'((x * 7 + y * 3) & 255);
        pixValid = 1'b1; pixX = x[15:0]; pixY = y[15:0]; pixIndex = idx;
        exp = refPix(x, y, idx);
        @(negedge clk);
        if (!(y >= curYRef && y < curYRef + 32)) req = "R7";
        else if (!(x >= curXRef && x < curXRef + 32 && x < widthRef && curXRef < widthRef)) req = "R8";
        else req = "R6";
        check(req, {23'd0, outIndex}, {23'd0, exp});
        check("R9", {31'd0, outValid}, 32'd1);
      end
    end
    pixValid = 1'b0;
    @(negedge clk);
    check("R9 valid drop", {31'd0, outValid}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int r = 0; r < 32; r++) begin maskRef[r] = '0; imgRef[r] = '0; end
    repeat (3) @(negedge clk);
    check("R1 outValid in reset", {31'd0, outValid}, 32'd0);
    check("R1 rdData in reset", regRdData, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state through the register interface
    regRead(12'h8FC, rd); check("R1 position", rd, 32'hF000_0000);
    regRead(12'h818, rd); check("R1 misc", rd, 32'h0200_0000);
    regRead(12'h900, rd); check("R1 mask row0", rd, 32'd0);
    regRead(12'h9FC, rd); check("R1 image row31", rd, 32'd0);
    pixValid = 1'b1; pixX = 16'd0; pixY = 16'd0; pixIndex = 8'h5A;
    @(negedge clk);
    pixValid = 1'b0;
    check("R1 no overlay", {23'd0, outIndex}, 32'h5A);

    // R2 / R4 / R5 register decode
    setPos(123, 456);
    regRead(12'h8FC, rd); check("R2 position", rd, {16'd123, 16'd456});
    regWrite(12'h818, 32'h1234_5678);
    regRead(12'h818, rd); check("R4 misc", rd, 32'h1234_5678 | 32'h0200_0000);
    regWrite(12'h818, 32'hFFFF_FFFF);
    regRead(12'h818, rd); check("R4 misc ones", rd, 32'hFFFF_FFFF);
    regRead(12'h9FC, rd); check("R9 read holds", regRdData, rd);
    regWrite(12'h900, 32'hCAFE_F00D);
    regWrite(12'h800, 32'hDEAD_BEEF);
    regWrite(12'hA00, 32'h1111_1111);
    regWrite(12'h8F8, 32'h2222_2222);
    regRead(12'h800, rd); check("R5 undecoded read", rd, 32'd0);
    regRead(12'hA00, rd); check("R5 read past image", rd, 32'd0);
    regRead(12'h8FC, rd); check("R5 position intact", rd, {16'd123, 16'd456});
    regRead(12'h900, rd); check("R5 mask row0 intact", rd, 32'hCAFE_F00D);
    regRead(12'h980, rd); check("R5 image row0 intact", rd, 32'd0);

    // R3 bitmap rows
    loadBitmaps(0);
    for (int r = 0; r < 32; r++) begin
      regRead(12'h900 + 12'(4 * r), rd); check("R3 mask readback", rd, maskRef[r]);
      regRead(12'h980 + 12'(4 * r), rd); check("R3 image readback", rd, imgRef[r]);
    end

    // R6/R7/R8 sweeps across several placements
    widthRef = 1024; screenWidth = 16'd1024;
    setPos(100, 50);   sweep();
    loadBitmaps(7);
    setPos(0, 0);      sweep();
    setPos(1010, 200); sweep();
    setPos(1024, 300); sweep();
    setPos(500, 16'hFFF0); sweep();
    loadBitmaps(19);
    widthRef = 40; screenWidth = 16'd40;
    setPos(39, 10);    sweep();
    setPos(8, 1);      sweep();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule